// File: doc/BRIEF.md
# Two-Character Decimal Text to Binary Converter

This block takes a pair of 8-bit ASCII characters that together spell a two-digit decimal number, the first being the tens place and the second the ones place. It returns the unsigned binary value of that number, from 0 to 99, on an 8-bit bus. Each character is screened on its own. Its high nibble must be exactly 3 and its low nibble must be no greater than 9. If either character fails, the block returns a reserved code of 8'hFF in place of a number and raises an error flag.

The arithmetic is combinational. The tens value is scaled by ten using shifts and adds, with no general multiplier, and bit 0 of the ones character goes straight to bit 0 of the result. By default a one-cycle output stage follows. It captures a new pair whenever `in_valid` is high and presents it together with `out_valid`.

The output stage is a two-state machine. `ST_IDLE` means no fresh result is on the bus. `ST_PRESENT` means a result captured on the previous edge is on the bus. Any edge with `in_valid` high moves the machine to `ST_PRESENT`, whether it starts from `ST_IDLE` or from `ST_PRESENT`. Any edge with `in_valid` low moves it to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `ascii2bin_pair`

## Requirements
- R1: A character is a valid digit only when its bits [7:4] equal 4'h3 and its bits [3:0] are at most 4'h9. Examples of invalid characters are 8'h2F, 8'h3A, 8'h41 and 8'h3A to 8'h3F.
- R2: For a valid pair, `result` equals ten times the tens digit value plus the ones digit value.
- R3: When the pair is valid, bit 0 of `result` equals bit 0 of the ones character.
- R4: When either character is invalid, `result` is 8'hFF and `err` is 1.
- R5: When both characters are valid, `err` is 0 and `result` is at most 99.
- R6: A pair sampled on an edge with `in_valid` high appears on `result` and `err` just after that edge, and `out_valid` is high for that cycle. `out_valid` is low after any edge where `in_valid` is low.
- R7: On an edge with `in_valid` low, `result` and `err` keep their previous values whatever the characters are.
- R8: A synchronous active-high `rst` clears `result` to 0 and drives `err` and `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample the character pair on this edge |
| tens_char | input | 8 | ASCII tens-place character |
| ones_char | input | 8 | ASCII ones-place character |
| result | output | 8 | Binary value 0..99, or 8'hFF on error |
| err | output | 1 | At least one character is not a decimal digit |
| out_valid | output | 1 | `result` and `err` hold a freshly sampled pair |

## Verification
The hardest cases to reach are the characters that sit right next to the digit range. These are 8'h2F, 8'h3A to 8'h3F, and codes whose low nibble is legal but whose high nibble is not. Uniform random characters almost never land there, and almost never produce both a valid pair and a one-sided failure. The stimulus therefore sweeps all 100 digit pairs exhaustively. It places each near-miss character in the tens slot and in the ones slot against a valid partner. It then mixes random characters with random `in_valid` gaps, so that the hold rule is checked while the inputs change underneath it.

// File: rtl/ascii2bin_pkg.sv
package ascii2bin_pkg;
    localparam int CHAR_W = 8;
    localparam int NIB_W  = 4;

    typedef logic [NIB_W-1:0] digit_t;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } stage_state_e;
endpackage

// File: rtl/ascii_digit_check.sv
module ascii_digit_check
    import ascii2bin_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic [W-1:0] ch,
    output digit_t       digit,
    output logic         ok
);
    localparam int HI_W = W - NIB_W;
    localparam logic [HI_W-1:0] ZONE = HI_W'(3);

    logic hi_ok;
    logic lo_ok;

    always_comb begin
        digit = ch[NIB_W-1:0];
        hi_ok = (ch[W-1:NIB_W] == ZONE);
        lo_ok = (ch[NIB_W-1:0] <= digit_t'(9));
        ok    = hi_ok && lo_ok;
    end
endmodule

// File: rtl/tens_ones_combine.sv
module tens_ones_combine
    import ascii2bin_pkg::*;
#(
    parameter int OUT_W = 8
) (
    input  digit_t             tens,
    input  digit_t             ones,
    output logic [OUT_W-1:0]   value
);
    localparam int UP_W = OUT_W - 1;

    logic [UP_W-1:0] upper;

    always_comb begin
        upper = (UP_W'(tens) << 2) + UP_W'(tens) + UP_W'(ones[NIB_W-1:1]);
        value = {upper, ones[0]};
    end
endmodule

// File: rtl/ascii2bin_pair.sv
module ascii2bin_pair
    import ascii2bin_pkg::*;
#(
    parameter int               OUT_W      = 8,
    parameter bit               REGISTERED = 1'b1,
    parameter logic [OUT_W-1:0] ERR_CODE   = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] tens_char,
    input  logic [CHAR_W-1:0] ones_char,
    output logic [OUT_W-1:0]  result,
    output logic              err,
    output logic              out_valid
);
    digit_t             tens_d;
    digit_t             ones_d;
    logic               tens_ok;
    logic               ones_ok;
    logic [OUT_W-1:0]   sum;
    logic [OUT_W-1:0]   conv;
    logic               bad;

    ascii_digit_check #(.W(CHAR_W)) u_chk_tens (
        .ch(tens_char), .digit(tens_d), .ok(tens_ok)
    );
    ascii_digit_check #(.W(CHAR_W)) u_chk_ones (
        .ch(ones_char), .digit(ones_d), .ok(ones_ok)
    );
    tens_ones_combine #(.OUT_W(OUT_W)) u_comb (
        .tens(tens_d), .ones(ones_d), .value(sum)
    );

    always_comb begin
        bad  = !(tens_ok && ones_ok);
        conv = bad ? ERR_CODE : sum;
    end

    generate
        if (REGISTERED) begin : g_reg
            stage_state_e     state;
            stage_state_e     state_nxt;
            logic [OUT_W-1:0] res_q;
            logic             err_q;

            always_ff @(posedge clk) begin
                if (rst) state <= ST_IDLE;
                else     state <= state_nxt;
            end

            always_comb begin
                state_nxt = state;
                unique case (state)
                    ST_IDLE:    state_nxt = in_valid ? ST_PRESENT : ST_IDLE;
                    ST_PRESENT: state_nxt = in_valid ? ST_PRESENT : ST_IDLE;
                    default:    state_nxt = ST_IDLE;
                endcase
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    res_q <= '0;
                    err_q <= 1'b0;
                end else if (in_valid) begin
                    res_q <= conv;
                    err_q <= bad;
                end
            end

            always_comb begin
                result    = res_q;
                err       = err_q;
                out_valid = (state == ST_PRESENT);
            end
        end else begin : g_comb
            always_comb begin
                result    = conv;
                err       = bad;
                out_valid = in_valid;
            end
        end
    endgenerate
endmodule

// File: rtl/ascii2bin_pair_chk.sv
module ascii2bin_pair_chk #(
    parameter int OUT_W      = 8,
    parameter bit REGISTERED = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [7:0]       tens_char,
    input logic [7:0]       ones_char,
    input logic [OUT_W-1:0] result,
    input logic             err,
    input logic             out_valid
);
    logic pair_ok;
    always_comb pair_ok = (tens_char[7:4] == 4'h3) && (tens_char[3:0] <= 4'h9)
                       && (ones_char[7:4] == 4'h3) && (ones_char[3:0] <= 4'h9);

    generate
        if (REGISTERED) begin : g_props
            // R8
            assert_reset_clears_R8: assert property (@(posedge clk)
                rst |=> (result == '0) && !err && !out_valid);
            // R6
            assert_strobe_follows_R6: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            assert_strobe_drops_R6: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
            // R7
            assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(result) && $stable(err));
            // R3
            assert_low_bit_R3: assert property (@(posedge clk) disable iff (rst)
                (in_valid && pair_ok) |=> (result[0] == $past(ones_char[0])) && !err);
            // R4
            assert_err_code_R4: assert property (@(posedge clk) disable iff (rst)
                (in_valid && !pair_ok) |=> err && (result == {OUT_W{1'b1}}));
            // R5
            assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
                !err |-> (result <= OUT_W'(99)));
        end
    endgenerate
endmodule

bind ascii2bin_pair ascii2bin_pair_chk #(.OUT_W(OUT_W), .REGISTERED(REGISTERED)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .tens_char(tens_char),
    .ones_char(ones_char), .result(result), .err(err), .out_valid(out_valid)
);

// File: tb/ascii2bin_pair_tb.sv
module ascii2bin_pair_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] tens_char = 8'h30;
    logic [7:0] ones_char = 8'h30;
    logic [7:0] result;
    logic       err;
    logic       out_valid;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ascii2bin_pair u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .tens_char(tens_char),
        .ones_char(ones_char), .result(result), .err(err), .out_valid(out_valid)
    );

    function automatic bit is_digit(input logic [7:0] c);
        return (c >= 8'h30) && (c <= 8'h39);
    endfunction

    function automatic logic [7:0] expect_val(input logic [7:0] t, input logic [7:0] o);
        if (!is_digit(t) || !is_digit(o)) return 8'hFF;
        return 8'((t - 8'h30) * 10 + (o - 8'h30));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] t, input logic [7:0] o, input string req);
        logic [7:0] ev;
        @(negedge clk);
        tens_char = t; ones_char = o; in_valid = 1'b1;
        @(posedge clk); #1;
        ev = expect_val(t, o);
        check(req, 32'(result), 32'(ev));
        check("R4/R5 err", 32'(err), 32'(ev == 8'hFF));
        check("R6 out_valid", 32'(out_valid), 32'd1);
        if (ev != 8'hFF) check("R3 bit0", 32'(result[0]), 32'(o[0]));
    endtask

    task automatic idle_cycle(input logic [7:0] t, input logic [7:0] o);
        logic [7:0] prev_r;
        logic       prev_e;
        @(negedge clk);
        prev_r = result; prev_e = err;
        tens_char = t; ones_char = o; in_valid = 1'b0;
        @(posedge clk); #1;
        check("R7 hold result", 32'(result), 32'(prev_r));
        check("R7 hold err", 32'(err), 32'(prev_e));
        check("R6 strobe low", 32'(out_valid), 32'd0);
    endtask

    initial begin
        logic [7:0] inv [6];
        inv[0] = 8'h2F; inv[1] = 8'h3A; inv[2] = 8'h41;
        inv[3] = 8'h3C; inv[4] = 8'h3F; inv[5] = 8'h05;
        void'($urandom(32'd20240517));

        @(posedge clk); @(posedge clk); #1;
        check("R8 reset result", 32'(result), 32'd0);
        check("R8 reset err", 32'(err), 32'd0);
        check("R8 reset out_valid", 32'(out_valid), 32'd0);
        @(negedge clk); rst = 1'b0;

        apply(8'h31, 8'h32, "R2 example 12");
        apply(8'h39, 8'h39, "R5 max 99");
        apply(8'h30, 8'h30, "R2 zero");

        for (int t = 0; t < 10; t++)
            for (int o = 0; o < 10; o++)
                apply(8'(8'h30 + t), 8'(8'h30 + o), "R2 sweep");

        for (int i = 0; i < 6; i++) begin
            apply(inv[i], 8'h35, "R1 R4 bad tens");
            apply(8'h37, inv[i], "R1 R4 bad ones");
        end
        for (int n = 10; n < 16; n++)
            apply(8'h32, 8'(8'h30 + n), "R1 low nibble A-F");
        apply(8'h41, 8'h2F, "R4 both bad");

        apply(8'h34, 8'h32, "R2 before hold");
        idle_cycle(8'h3A, 8'h99);
        idle_cycle(8'h31, 8'h31);
        apply(8'h3B, 8'h30, "R4 before hold");
        idle_cycle(8'h35, 8'h35);

        for (int k = 0; k < 400; k++) begin
            logic [7:0] t;
            logic [7:0] o;
            t = ($urandom % 2) ? 8'(8'h30 + $urandom % 10) : 8'($urandom);
            o = ($urandom % 2) ? 8'(8'h30 + $urandom % 10) : 8'($urandom);
            if ($urandom % 4 == 0) idle_cycle(t, o);
            else apply(t, o, "R2 R4 random");
        end

        @(negedge clk); rst = 1'b1; in_valid = 1'b1;
        @(posedge clk); #1;
        check("R8 mid reset result", 32'(result), 32'd0);
        check("R8 mid reset out_valid", 32'(out_valid), 32'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule